// File: doc/BRIEF.md
# Period-Latched Counter PWM Generator

This block produces a fixed-frequency pulse-width-modulated output from a free-running binary counter, an equality comparator and a two-state set/clear output latch. The period is 2^CNT_W clocks. At the overflow of the counter the output latch is set and, in the same clock, the pending duty word is copied into a holding register. When the count reaches the held duty value the latch is cleared. The output is therefore high for the first K clocks of each period and low for the rest, giving a duty cycle of K/2^CNT_W.

Because the duty word is only sampled at overflow, software or a control loop may change the input at any time without producing a shortened or doubled pulse: the new value applies from the next period onward. A one-clock strobe marks the first clock of every period so that a controller can align its updates. A parameter selects between a single counter and two cascaded half-width counters joined by a carry, with identical behaviour at the ports.

The latch is written as a small state machine with two states, `ST_OFF` and `ST_ON`. Its transitions are `SET` (ST_OFF to ST_ON at overflow with a nonzero pending duty), `CLEAR` (ST_ON to ST_OFF when the next count equals the held duty), `HOLD_ZERO` (any state to ST_OFF at overflow with a zero pending duty, where the clear event overrides the set event) and `STAY` (no event).

Top module: `pwm_latch_gen`

## Requirements
- R1: The counter advances by one on every clock after reset and wraps from 2^CNT_W-1 to 0, so the period is exactly 2^CNT_W clocks.
- R2: `period_start_o` is high for exactly one clock per period, in the clock where the count is zero after a wrap; it is never high in the first period after reset.
- R3: The duty input is captured only at overflow; a change to `duty_i` during a period has no effect on the output until the next period begins.
- R4: With a held duty value K in 1..2^CNT_W-1, `pwm_o` is high for count values 0..K-1 and low for count values K..2^CNT_W-1 (for CNT_W=4, K=9 gives 9 of 16 clocks, K=15 gives 15 of 16).
- R5: A held duty value of zero keeps `pwm_o` low for the whole period; a simultaneous set and clear resolves to low.
- R6: With CASCADE=1 the count is built from a low and a high half-width counter, the high half advancing only on the low half's carry, and the port behaviour is identical to the single-counter build.
- R7: While `rst_ni` is low, `pwm_o` and `period_start_o` are low; after release the held duty is zero, so the output stays low until the first overflow loads a duty word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| duty_i | input | CNT_W | Pending duty word, sampled at overflow |
| pwm_o | output | 1 | PWM output from the set/clear latch |
| period_start_o | output | 1 | One-clock strobe in the first clock of each period |

## Verification
The bench builds two instances side by side: one with CNT_W=4 and a single counter, where a 16-clock period lets many periods, every boundary duty value and mid-period changes fit in a short run; and one with CNT_W=8 and CASCADE=1, where the 256-clock period exercises the carry between the two halves and the extreme values 1 and 255. A behavioural model of count, held duty and expected output is compared with both instances on every clock, including a reset applied in the middle of a period.

// File: rtl/pwm_latch_pkg.sv
package pwm_latch_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } pwm_state_e;

endpackage

// File: rtl/pwm_free_counter.sv
module pwm_free_counter #(
    parameter int CNT_W   = 4,
    parameter bit CASCADE = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    generate
        if (CASCADE) begin : g_cascade
            localparam int HALF_W = CNT_W / 2;
            logic [HALF_W-1:0] lo_q;
            logic [HALF_W-1:0] hi_q;
            logic              lo_carry;
            logic              hi_carry;

            assign lo_carry = &lo_q;
            assign hi_carry = &hi_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    lo_q <= '0;
                end else begin
                    lo_q <= lo_q + HALF_W'(1);
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    hi_q <= '0;
                end else if (lo_carry) begin
                    hi_q <= hi_q + HALF_W'(1);
                end
            end

            assign cnt_o  = {hi_q, lo_q};
            assign wrap_o = lo_carry & hi_carry;
        end else begin : g_flat
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end

            assign cnt_o  = cnt_q;
            assign wrap_o = &cnt_q;
        end
    endgenerate

    // R1
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));

endmodule

// File: rtl/pwm_duty_hold.sv
module pwm_duty_hold #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic [CNT_W-1:0] duty_q_o
);

    logic [CNT_W-1:0] held_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            held_q <= '0;
        end else if (load_i) begin
            held_q <= duty_i;
        end
    end

    assign duty_q_o = held_q;

    // R3
    duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(duty_q_o));

endmodule

// File: rtl/pwm_latch_fsm.sv
module pwm_latch_fsm
    import pwm_latch_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] duty_pend_i,
    input  logic [CNT_W-1:0] duty_held_i,
    output logic             pwm_o,
    output logic             start_o
);

    pwm_state_e state_q;
    pwm_state_e state_d;
    logic       start_q;
    logic       set_ev;
    logic       clr_ev;

    assign set_ev = wrap_i;
    assign clr_ev = wrap_i ? (duty_pend_i == '0) : (cnt_next_i == duty_held_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (set_ev && !clr_ev) begin
                    state_d = ST_ON;
                end
            end
            ST_ON: begin
                if (clr_ev) begin
                    state_d = ST_OFF;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= wrap_i;
        end
    end

    always_comb begin
        pwm_o   = (state_q == ST_ON);
        start_o = start_q;
    end

    // R4
    rise_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwm_o) |-> start_o);

    // R5
    zero_duty_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o && duty_held_i == '0) |-> !pwm_o);

    // R2
    start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);

endmodule

// File: rtl/pwm_latch_gen.sv
module pwm_latch_gen #(
    parameter int CNT_W   = 4,
    parameter bit CASCADE = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o,
    output logic             period_start_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             wrap;
    logic [CNT_W-1:0] duty_held;

    pwm_free_counter #(
        .CNT_W   (CNT_W),
        .CASCADE (CASCADE)
    ) u_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    assign cnt_next = cnt + CNT_W'(1);

    pwm_duty_hold #(
        .CNT_W (CNT_W)
    ) u_hold (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (wrap),
        .duty_i   (duty_i),
        .duty_q_o (duty_held)
    );

    pwm_latch_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wrap_i      (wrap),
        .cnt_next_i  (cnt_next),
        .duty_pend_i (duty_i),
        .duty_held_i (duty_held),
        .pwm_o       (pwm_o),
        .start_o     (period_start_o)
    );

    // R2
    start_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_start_o |-> (cnt == '0));

    // R4
    fall_at_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pwm_o) |-> (cnt == duty_held));

    // R4
    high_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_start_o && duty_held != '0) |-> pwm_o);

endmodule

// File: tb/pwm_latch_gen_tb_top.sv
module pwm_latch_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] duty_a;
    logic [7:0] duty_b;
    logic       pwm_a, start_a, pwm_b, start_b;

    always #4 clk = ~clk;

    pwm_latch_gen #(.CNT_W(4), .CASCADE(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .duty_i(duty_a),
        .pwm_o(pwm_a), .period_start_o(start_a));

    pwm_latch_gen #(.CNT_W(8), .CASCADE(1'b1)) dut_casc_i (
        .clk_i(clk), .rst_ni(rst_n), .duty_i(duty_b),
        .pwm_o(pwm_b), .period_start_o(start_b));

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int m_cnt [2] = '{0, 0};
    int m_held[2] = '{0, 0};
    bit m_pwm [2] = '{0, 0};
    bit m_start[2] = '{0, 0};
    int last_start[2] = '{-1, -1};
    bit done = 1'b0;

    function automatic int period_of(int i);
        return (i == 0) ? 16 : 256;
    endfunction

    function automatic int duty_of(int i);
        return (i == 0) ? int'(duty_a) : int'(duty_b);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // behavioural reference: count, held duty, output
    always @(posedge clk) begin
        cyc++;
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                m_cnt[i] = 0; m_held[i] = 0; m_pwm[i] = 0; m_start[i] = 0;
            end else begin
                if (m_cnt[i] == period_of(i) - 1) begin
                    m_cnt[i] = 0;
                    m_held[i] = duty_of(i);
                    m_start[i] = 1;
                end else begin
                    m_cnt[i] = m_cnt[i] + 1;
                    m_start[i] = 0;
                end
                m_pwm[i] = (m_cnt[i] < m_held[i]);
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < 2; i++) begin
                bit   p, s;
                string tp, ts;
                p = (i == 0) ? pwm_a : pwm_b;
                s = (i == 0) ? start_a : start_b;
                if (i == 1) begin
                    tp = "R6 pwm"; ts = "R6 start";
                end else if (!rst_n) begin
                    tp = "R7 pwm"; ts = "R7 start";
                end else if (m_held[i] == 0) begin
                    tp = "R5 pwm"; ts = "R2 start";
                end else if (duty_of(i) != m_held[i]) begin
                    tp = "R3 pwm"; ts = "R2 start";
                end else begin
                    tp = "R4 pwm"; ts = "R2 start";
                end
                check(p == m_pwm[i], tp, int'(p), int'(m_pwm[i]));
                check(s == m_start[i], ts, int'(s), int'(m_start[i]));
                if (!rst_n) begin
                    last_start[i] = -1;
                end else if (s) begin
                    if (last_start[i] >= 0)
                        check(cyc - last_start[i] == period_of(i), "R1 period",
                              cyc - last_start[i], period_of(i));
                    last_start[i] = cyc;
                end
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; duty_a = 4'd9; duty_b = 8'd128;
        run(3);
        check(pwm_a == 1'b0 && start_a == 1'b0, "R7 reset state", int'(pwm_a), 0);
        rst_n = 1'b1;
        run(40);                          // first period low, then K=9
        duty_a = 4'd15; run(50);
        duty_a = 4'd0;  run(5);           // mid-period change: R3
        run(40);
        duty_a = 4'd1; duty_b = 8'd1; run(300);
        duty_a = 4'd8; duty_b = 8'd255; run(7);
        duty_a = 4'd3; run(520);
        duty_b = 8'd0; duty_a = 4'd12; run(300);
        rst_n = 1'b0; run(2);             // reset mid-period: R7
        rst_n = 1'b1; duty_b = 8'd77; run(600);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 200000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule